// File: doc/BRIEF.md
# Dual-Port FIFO Access Decoder with Mailboxes

This block sits between two 36-bit ports and a shared FIFO. Each port runs on its own clock and has four control inputs: an active-low chip select, a transfer-direction select, an enable and a mailbox select. The block decodes these inputs into a FIFO write strobe for port A and a FIFO read strobe for port B. It also decodes strobes for two mailbox registers, which carry single words in each direction beside the FIFO. There are no tri-state drivers. Each port instead gets an output-enable signal and a selected output word.

Mailbox 1 carries data from port A to port B, and mailbox 2 carries data from port B to port A. Each mailbox has a flag, high when empty, that lives in the writing port's clock domain. An accepted write drives the flag low. A read from the opposite port raises it again once that read has crossed the clock boundary. The FIFO storage and its input-ready and output-ready flags are outside the block.

Top module: `mbx_port_decoder`

## Requirements
- R1: `a_oe` is 1 exactly when `a_cs_n`=0 and `a_xfer_dir`=0 (port A: 1 = write into the block, 0 = read out). `a_dout` always carries mailbox 2.
- R2: `b_oe` is 1 exactly when `b_cs_n`=0 and `b_xfer_dir`=1 (port B: 1 = read out, 0 = write into the block). `b_dout` carries mailbox 1 when `b_mbx`=1 and `fifo_q` when `b_mbx`=0.
- R3: `fifo_wr` is 1 exactly when `a_cs_n`=0, `a_xfer_dir`=1, `a_en`=1, `a_mbx`=0 and `in_ready`=1.
- R4: `fifo_rd` is 1 exactly when `b_cs_n`=0, `b_xfer_dir`=1, `b_en`=1, `b_mbx`=0 and `out_ready`=1.
- R5: `a_mb1_wr` is 1 exactly when `a_cs_n`=0, `a_en`=1, `a_mbx`=1 and `a_xfer_dir`=1. `a_mb2_rd` is 1 under the same conditions except that `a_xfer_dir`=0.
- R6: `b_mb2_wr` is 1 exactly when `b_cs_n`=0, `b_en`=1, `b_mbx`=1 and `b_xfer_dir`=0. `b_mb1_rd` is 1 under the same conditions except that `b_xfer_dir`=1.
- R7: After reset, `mbf1` and `mbf2` are 1 and both mailboxes hold zero.
- R8: When a mailbox write strobe is seen at a rising edge of the writer's clock while that mailbox's flag is 1, the mailbox takes the writer's input data. The flag reads 0 right after that edge.
- R9: A mailbox write strobe seen while that mailbox's flag is 0 leaves the mailbox contents unchanged.
- R10: A read strobe of a full mailbox, taken at a reader clock edge, returns the flag to 1 exactly SYNC_STAGES (default 2) writer-clock edges later. The flag stays 0 before that.
- R11: With chip select high or enable low, a port raises no strobe and changes no mailbox or flag.
- R12: `fifo_wr` and `fifo_rd` can both be 1 in the same cycle, and neither depends on the other port's controls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously per domain |
| in_ready | input | 1 | FIFO can accept a word (from the FIFO) |
| out_ready | input | 1 | FIFO has a word to read (from the FIFO) |
| fifo_q | input | 36 | FIFO output register |
| fifo_wr | output | 1 | FIFO write strobe, port A domain; the FIFO takes `a_din` |
| fifo_rd | output | 1 | FIFO read strobe, port B domain |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_xfer_dir | input | 1 | Port A direction: 1 write, 0 read |
| a_en | input | 1 | Port A enable |
| a_mbx | input | 1 | Port A mailbox select |
| a_din | input | 36 | Port A input data |
| a_dout | output | 36 | Port A output data (mailbox 2) |
| a_oe | output | 1 | Port A output enable |
| a_mb1_wr | output | 1 | Mailbox 1 write strobe |
| a_mb2_rd | output | 1 | Mailbox 2 read strobe |
| mbf1 | output | 1 | Mailbox 1 empty flag, port A domain |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_xfer_dir | input | 1 | Port B direction: 1 read, 0 write |
| b_en | input | 1 | Port B enable |
| b_mbx | input | 1 | Port B mailbox select |
| b_din | input | 36 | Port B input data |
| b_dout | output | 36 | Port B output data |
| b_oe | output | 1 | Port B output enable |
| b_mb2_wr | output | 1 | Mailbox 2 write strobe |
| b_mb1_rd | output | 1 | Mailbox 1 read strobe |
| mbf2 | output | 1 | Mailbox 2 empty flag, port B domain |

## Verification
The decoders are tried with every combination of chip select, direction, enable, mailbox select and the FIFO ready flag on each port. These sweeps tell the FIFO strobe apart from the two mailbox strobes. They also show that the opposite direction polarity of the two ports is decoded correctly. Mailbox traffic is tested in three situations: a write to an empty mailbox, a second write while it is full, and a write with enable low. The results separate accepted writes from ignored ones. The flag is sampled one edge before and on the edge where the read is expected to land, which pins down the crossing latency.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  localparam int unsigned WORD_W = 36;

  typedef struct packed {
    logic cs_n;
    logic dir;
    logic en;
    logic mbx;
  } port_ctrl_t;

  typedef struct packed {
    logic oe;
    logic fifo_stb;
    logic mb_wr;
    logic mb_rd;
  } port_dec_t;
endpackage

// File: rtl/mbx_bit_sync.sv
`timescale 1ns/1ps
module mbx_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = d;
    end else begin : g_chain
      always_comb sh_d = {sh_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/mbx_port_dec.sv
`timescale 1ns/1ps
module mbx_port_dec
  import mbx_pkg::*;
#(
  parameter bit DIR_HIGH_WRITES = 1'b1,
  parameter bit FIFO_ON_WRITE   = 1'b1
) (
  input  port_ctrl_t ctrl,
  input  logic       fifo_ok,
  output port_dec_t  dec
);
  logic is_write;
  logic active;
  logic fifo_dir;

  generate
    if (DIR_HIGH_WRITES) begin : g_hi_wr
      assign is_write = ctrl.dir;
    end else begin : g_lo_wr
      assign is_write = ~ctrl.dir;
    end
    if (FIFO_ON_WRITE) begin : g_fifo_wr
      assign fifo_dir = is_write;
    end else begin : g_fifo_rd
      assign fifo_dir = ~is_write;
    end
  endgenerate

  assign active = ~ctrl.cs_n & ctrl.en;

  always_comb begin
    dec.oe       = ~ctrl.cs_n & ~is_write;
    dec.fifo_stb = active & ~ctrl.mbx & fifo_dir & fifo_ok;
    dec.mb_wr    = active & ctrl.mbx & is_write;
    dec.mb_rd    = active & ctrl.mbx & ~is_write;
  end
endmodule

// File: rtl/mbx_link.sv
`timescale 1ns/1ps
module mbx_link #(
  parameter int unsigned W      = 36,
  parameter int unsigned STAGES = 2
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         rclk,
  input  logic         rrst_n,
  input  logic         wr_req,
  input  logic [W-1:0] wdata,
  input  logic         rd_req,
  output logic [W-1:0] data,
  output logic         empty_w
);
  logic         wtog_q, wtog_d;
  logic         rtog_q, rtog_d;
  logic         wtog_s, rtog_s;
  logic [W-1:0] data_q, data_d;
  logic         wr_take, rd_take, full_r;

  // writer domain sees the reader's toggle through a synchronizer
  assign empty_w = (wtog_q == rtog_s);
  assign wr_take = wr_req & empty_w;
  // reader domain sees the writer's toggle through a synchronizer
  assign full_r  = (wtog_s != rtog_q);
  assign rd_take = rd_req & full_r;

  always_comb begin
    wtog_d = wtog_q ^ wr_take;
    data_d = wr_take ? wdata : data_q;
    rtog_d = rtog_q ^ rd_take;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wtog_q <= 1'b0;
      data_q <= '0;
    end else begin
      wtog_q <= wtog_d;
      data_q <= data_d;
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) rtog_q <= 1'b0;
    else         rtog_q <= rtog_d;
  end

  mbx_bit_sync #(.STAGES(STAGES)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wtog_q), .q(wtog_s)
  );
  mbx_bit_sync #(.STAGES(STAGES)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rtog_q), .q(rtog_s)
  );

  assign data = data_q;
endmodule

// File: rtl/mbx_port_decoder.sv
`timescale 1ns/1ps
module mbx_port_decoder
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W      = WORD_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              rst_n,
  input  logic              in_ready,
  input  logic              out_ready,
  input  logic [DATA_W-1:0] fifo_q,
  output logic              fifo_wr,
  output logic              fifo_rd,
  input  logic              a_cs_n,
  input  logic              a_xfer_dir,
  input  logic              a_en,
  input  logic              a_mbx,
  input  logic [DATA_W-1:0] a_din,
  output logic [DATA_W-1:0] a_dout,
  output logic              a_oe,
  output logic              a_mb1_wr,
  output logic              a_mb2_rd,
  output logic              mbf1,
  input  logic              b_cs_n,
  input  logic              b_xfer_dir,
  input  logic              b_en,
  input  logic              b_mbx,
  input  logic [DATA_W-1:0] b_din,
  output logic [DATA_W-1:0] b_dout,
  output logic              b_oe,
  output logic              b_mb2_wr,
  output logic              b_mb1_rd,
  output logic              mbf2
);
  localparam int unsigned RST_STAGES = 2;

  logic              rst_a_n, rst_b_n;
  port_ctrl_t        ctl_a, ctl_b;
  port_dec_t         dec_a, dec_b;
  logic [DATA_W-1:0] mb1_data, mb2_data;

  mbx_bit_sync #(.STAGES(RST_STAGES)) u_rsync_a (
    .clk(clk_a), .rst_n(rst_n), .d(1'b1), .q(rst_a_n)
  );
  mbx_bit_sync #(.STAGES(RST_STAGES)) u_rsync_b (
    .clk(clk_b), .rst_n(rst_n), .d(1'b1), .q(rst_b_n)
  );

  assign ctl_a = '{cs_n: a_cs_n, dir: a_xfer_dir, en: a_en, mbx: a_mbx};
  assign ctl_b = '{cs_n: b_cs_n, dir: b_xfer_dir, en: b_en, mbx: b_mbx};

  mbx_port_dec #(.DIR_HIGH_WRITES(1'b1), .FIFO_ON_WRITE(1'b1)) u_dec_a (
    .ctrl(ctl_a), .fifo_ok(in_ready), .dec(dec_a)
  );
  mbx_port_dec #(.DIR_HIGH_WRITES(1'b0), .FIFO_ON_WRITE(1'b0)) u_dec_b (
    .ctrl(ctl_b), .fifo_ok(out_ready), .dec(dec_b)
  );

  // mailbox 1: written from port A, read from port B
  mbx_link #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_mb1 (
    .wclk(clk_a), .wrst_n(rst_a_n), .rclk(clk_b), .rrst_n(rst_b_n),
    .wr_req(dec_a.mb_wr), .wdata(a_din), .rd_req(dec_b.mb_rd),
    .data(mb1_data), .empty_w(mbf1)
  );
  // mailbox 2: written from port B, read from port A
  mbx_link #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_mb2 (
    .wclk(clk_b), .wrst_n(rst_b_n), .rclk(clk_a), .rrst_n(rst_a_n),
    .wr_req(dec_b.mb_wr), .wdata(b_din), .rd_req(dec_a.mb_rd),
    .data(mb2_data), .empty_w(mbf2)
  );

  assign fifo_wr  = dec_a.fifo_stb;
  assign fifo_rd  = dec_b.fifo_stb;
  assign a_oe     = dec_a.oe;
  assign b_oe     = dec_b.oe;
  assign a_mb1_wr = dec_a.mb_wr;
  assign a_mb2_rd = dec_a.mb_rd;
  assign b_mb2_wr = dec_b.mb_wr;
  assign b_mb1_rd = dec_b.mb_rd;
  assign a_dout   = mb2_data;
  assign b_dout   = b_mbx ? mb1_data : fifo_q;
endmodule

// File: rtl/mbx_port_decoder_chk.sv
`timescale 1ns/1ps
module mbx_port_decoder_chk #(
  parameter int unsigned DATA_W = 36
) (
  input logic              clk_a,
  input logic              clk_b,
  input logic              rst_n,
  input logic              a_cs_n,
  input logic              a_en,
  input logic              b_cs_n,
  input logic              b_en,
  input logic              fifo_wr,
  input logic              fifo_rd,
  input logic              a_mb1_wr,
  input logic              a_mb2_rd,
  input logic              b_mb2_wr,
  input logic              b_mb1_rd,
  input logic              mbf1,
  input logic              mbf2,
  input logic [DATA_W-1:0] mb1_data,
  input logic [DATA_W-1:0] mb2_data
);
  AST_A_IDLE_QUIET: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_cs_n || !a_en) |-> !(fifo_wr || a_mb1_wr || a_mb2_rd)); // R11
  AST_B_IDLE_QUIET: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_cs_n || !b_en) |-> !(fifo_rd || b_mb2_wr || b_mb1_rd)); // R11
  AST_A_ONE_ACTION: assert property (@(posedge clk_a) disable iff (!rst_n)
    $onehot0({fifo_wr, a_mb1_wr, a_mb2_rd})); // R5
  AST_B_ONE_ACTION: assert property (@(posedge clk_b) disable iff (!rst_n)
    $onehot0({fifo_rd, b_mb2_wr, b_mb1_rd})); // R6
  AST_MBF1_FALL_CAUSE: assert property (@(posedge clk_a) disable iff (!rst_n)
    $fell(mbf1) |-> $past(a_mb1_wr)); // R8
  AST_MBF2_FALL_CAUSE: assert property (@(posedge clk_b) disable iff (!rst_n)
    $fell(mbf2) |-> $past(b_mb2_wr)); // R8
  AST_MB1_HOLD_FULL: assert property (@(posedge clk_a) disable iff (!rst_n)
    !mbf1 |=> $stable(mb1_data)); // R9
  AST_MB2_HOLD_FULL: assert property (@(posedge clk_b) disable iff (!rst_n)
    !mbf2 |=> $stable(mb2_data)); // R9
endmodule

bind mbx_port_decoder mbx_port_decoder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
  .a_cs_n(a_cs_n), .a_en(a_en), .b_cs_n(b_cs_n), .b_en(b_en),
  .fifo_wr(fifo_wr), .fifo_rd(fifo_rd),
  .a_mb1_wr(a_mb1_wr), .a_mb2_rd(a_mb2_rd),
  .b_mb2_wr(b_mb2_wr), .b_mb1_rd(b_mb1_rd),
  .mbf1(mbf1), .mbf2(mbf2), .mb1_data(mb1_data), .mb2_data(mb2_data)
);

// File: tb/mbx_port_decoder_bench.sv
`timescale 1ns/1ps
module mbx_port_decoder_bench;
  localparam int W = 36;

  logic clk = 1'b0;
  logic rst_n;
  logic in_ready, out_ready;
  logic [W-1:0] fifo_q;
  logic fifo_wr, fifo_rd;
  logic a_cs_n, a_xfer_dir, a_en, a_mbx;
  logic [W-1:0] a_din, a_dout;
  logic a_oe, a_mb1_wr, a_mb2_rd, mbf1;
  logic b_cs_n, b_xfer_dir, b_en, b_mbx;
  logic [W-1:0] b_din, b_dout;
  logic b_oe, b_mb2_wr, b_mb1_rd, mbf2;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  mbx_port_decoder u_mbx_port_decoder (
    .clk_a(clk), .clk_b(clk), .rst_n(rst_n),
    .in_ready(in_ready), .out_ready(out_ready), .fifo_q(fifo_q),
    .fifo_wr(fifo_wr), .fifo_rd(fifo_rd),
    .a_cs_n(a_cs_n), .a_xfer_dir(a_xfer_dir), .a_en(a_en), .a_mbx(a_mbx),
    .a_din(a_din), .a_dout(a_dout), .a_oe(a_oe),
    .a_mb1_wr(a_mb1_wr), .a_mb2_rd(a_mb2_rd), .mbf1(mbf1),
    .b_cs_n(b_cs_n), .b_xfer_dir(b_xfer_dir), .b_en(b_en), .b_mbx(b_mbx),
    .b_din(b_din), .b_dout(b_dout), .b_oe(b_oe),
    .b_mb2_wr(b_mb2_wr), .b_mb1_rd(b_mb1_rd), .mbf2(mbf2)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    a_cs_n = 1'b1; a_xfer_dir = 1'b0; a_en = 1'b0; a_mbx = 1'b0;
    b_cs_n = 1'b1; b_xfer_dir = 1'b0; b_en = 1'b0; b_mbx = 1'b0;
    in_ready = 1'b0; out_ready = 1'b0;
  endtask

  task automatic t_reset();
    idle();
    a_din = '0; b_din = '0; fifo_q = 36'h0_DEAD_BEEF;
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R7 mbf1", {35'd0, mbf1}, 36'd1);
    chk("R7 mbf2", {35'd0, mbf2}, 36'd1);
    chk("R7 mailbox2 cleared", a_dout, '0);
    b_mbx = 1'b1; #1;
    chk("R7 mailbox1 cleared", b_dout, '0);
    b_mbx = 1'b0;
  endtask

  task automatic t_port_a_decode();
    for (int i = 0; i < 32; i++) begin
      logic cs, dr, en, mb, rd;
      {cs, dr, en, mb, rd} = i[4:0];
      a_cs_n = cs; a_xfer_dir = dr; a_en = en; a_mbx = mb; in_ready = rd;
      #1;
      chk((cs || !en) ? "R11 fifo_wr" : "R3 fifo_wr", {35'd0, fifo_wr},
          {35'd0, !cs & dr & en & !mb & rd});
      chk((cs || !en) ? "R11 a_mb1_wr" : "R5 a_mb1_wr", {35'd0, a_mb1_wr},
          {35'd0, !cs & dr & en & mb});
      chk((cs || !en) ? "R11 a_mb2_rd" : "R5 a_mb2_rd", {35'd0, a_mb2_rd},
          {35'd0, !cs & !dr & en & mb});
      chk("R1 a_oe", {35'd0, a_oe}, {35'd0, !cs & !dr});
      a_cs_n = 1'b1;
      @(negedge clk);
    end
    idle();
  endtask

  task automatic t_port_b_decode();
    for (int i = 0; i < 32; i++) begin
      logic cs, dr, en, mb, rd;
      {cs, dr, en, mb, rd} = i[4:0];
      b_cs_n = cs; b_xfer_dir = dr; b_en = en; b_mbx = mb; out_ready = rd;
      #1;
      chk((cs || !en) ? "R11 fifo_rd" : "R4 fifo_rd", {35'd0, fifo_rd},
          {35'd0, !cs & dr & en & !mb & rd});
      chk((cs || !en) ? "R11 b_mb1_rd" : "R6 b_mb1_rd", {35'd0, b_mb1_rd},
          {35'd0, !cs & dr & en & mb});
      chk((cs || !en) ? "R11 b_mb2_wr" : "R6 b_mb2_wr", {35'd0, b_mb2_wr},
          {35'd0, !cs & !dr & en & mb});
      chk("R2 b_oe", {35'd0, b_oe}, {35'd0, !cs & dr});
      b_cs_n = 1'b1;
      @(negedge clk);
    end
    idle();
  endtask

  task automatic t_bmux_and_concurrency();
    fifo_q = 36'h5_1234_5678;
    b_cs_n = 1'b0; b_xfer_dir = 1'b1; b_mbx = 1'b0; #1;
    chk("R2 b_dout fifo path", b_dout, 36'h5_1234_5678);
    a_cs_n = 1'b0; a_xfer_dir = 1'b1; a_en = 1'b1; in_ready = 1'b1;
    b_en = 1'b1; out_ready = 1'b1; #1;
    chk("R12 fifo_wr concurrent", {35'd0, fifo_wr}, 36'd1);
    chk("R12 fifo_rd concurrent", {35'd0, fifo_rd}, 36'd1);
    b_cs_n = 1'b1; #1;
    chk("R12 fifo_wr without port B", {35'd0, fifo_wr}, 36'd1);
    idle();
    @(negedge clk);
  endtask

  task automatic t_mailbox1();
    a_din = 36'hA_5A5A_0001;
    a_cs_n = 1'b0; a_xfer_dir = 1'b1; a_en = 1'b1; a_mbx = 1'b1;
    tick();
    idle();
    b_mbx = 1'b1; #1;
    chk("R8 mbf1 low after write", {35'd0, mbf1}, 36'd0);
    chk("R8 mailbox1 captured", b_dout, 36'hA_5A5A_0001);
    a_din = 36'h3_0000_0BAD;
    a_cs_n = 1'b0; a_xfer_dir = 1'b1; a_en = 1'b1; a_mbx = 1'b1;
    tick();
    a_en = 1'b0;
    tick();
    idle(); b_mbx = 1'b1; #1;
    chk("R9 write while full ignored", b_dout, 36'hA_5A5A_0001);
    repeat (2) tick();
    b_cs_n = 1'b0; b_xfer_dir = 1'b1; b_en = 1'b1; b_mbx = 1'b1;
    tick();
    idle();
    chk("R10 mbf1 still low at read edge", {35'd0, mbf1}, 36'd0);
    tick();
    chk("R10 mbf1 low one edge later", {35'd0, mbf1}, 36'd0);
    tick();
    chk("R10 mbf1 high after sync", {35'd0, mbf1}, 36'd1);
    a_din = 36'h7_7777_0002;
    a_cs_n = 1'b1; a_xfer_dir = 1'b1; a_en = 1'b1; a_mbx = 1'b1;
    tick();
    b_mbx = 1'b1; #1;
    chk("R11 cs high no mailbox write", {35'd0, mbf1}, 36'd1);
    chk("R11 mailbox1 kept", b_dout, 36'hA_5A5A_0001);
    a_cs_n = 1'b0;
    tick();
    idle(); b_mbx = 1'b1; #1;
    chk("R8 rewrite after drain", b_dout, 36'h7_7777_0002);
    idle();
  endtask

  task automatic t_mailbox2();
    b_din = 36'hC_0FFE_0003;
    b_cs_n = 1'b0; b_xfer_dir = 1'b0; b_en = 1'b1; b_mbx = 1'b1;
    tick();
    idle(); #1;
    chk("R8 mbf2 low after write", {35'd0, mbf2}, 36'd0);
    chk("R1 a_dout shows mailbox2", a_dout, 36'hC_0FFE_0003);
    b_din = 36'h1_1111_1111;
    b_cs_n = 1'b0; b_xfer_dir = 1'b0; b_en = 1'b1; b_mbx = 1'b1;
    tick();
    idle(); #1;
    chk("R9 mailbox2 write while full", a_dout, 36'hC_0FFE_0003);
    repeat (2) tick();
    a_cs_n = 1'b0; a_xfer_dir = 1'b0; a_en = 1'b1; a_mbx = 1'b1;
    tick();
    idle();
    chk("R10 mbf2 low at read edge", {35'd0, mbf2}, 36'd0);
    tick();
    chk("R10 mbf2 low one edge later", {35'd0, mbf2}, 36'd0);
    tick();
    chk("R10 mbf2 high after sync", {35'd0, mbf2}, 36'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_port_a_decode();
    t_port_b_decode();
    t_bmux_and_concurrency();
    t_mailbox1();
    t_mailbox2();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule